// File: doc/BRIEF.md
# Speculative Cache Line State Manager

This block keeps the per-line bookkeeping of a direct-mapped data cache that can hold safe and speculative contents side by side. Each line carries a tag and three flags: valid, dirty and speculative. On every accepted access it decides whether the access hits, which line gets filled or updated, whether a victim or a safe copy must be written back to memory, and whether an access has to be refused because its only victim is speculative.

Software opens a speculative section with a begin command. It closes the section with either a commit or a rollback. Either close command starts a sweep over every line, one index per cycle. A commit sweep turns speculative lines into ordinary dirty lines. A rollback sweep throws speculative lines away. The sweep is followed by one restore cycle, after which the cache is back in normal mode. Accesses are refused for the whole time the block reports busy.

Top module: `spec_line_mgr`

## Requirements
- R1: After reset every line is invalid, `busy`, `spec_active`, `rsp_valid`, `wb_valid` and `evict_ovf` are low, and the first read of any index misses.
- R2: A request accepted in one cycle gets `rsp_valid` high in the next cycle. `rsp_hit` is high only when the indexed line is valid and its tag equals `acc_tag`. A read miss fills the line with the new tag, marked clean.
- R3: Outside speculation, a write marks its line dirty. A miss whose victim is valid, dirty and not speculative raises `wb_valid` in the response cycle, with the victim's index on `wb_index` and its old tag on `wb_tag`.
- R4: `cmd_begin` sets `spec_active` in the next cycle. A begin is ignored while speculation is already active or while the block is busy.
- R5: During speculation, a write sets the line's speculative and dirty flags. A write hit on a line that is dirty and not yet speculative first issues a write-back of that line, carrying its own index and tag. Further writes to an already speculative line issue no write-back.
- R6: A miss whose victim is valid and speculative raises `evict_ovf`, keeps `rsp_hit` and `wb_valid` low, and leaves the victim in place, so that it still hits afterwards.
- R7: A commit or rollback accepted while speculation is active raises `busy` from the next cycle for exactly 2^INDEX_W + 1 cycles: one cycle per line, then one restore cycle. `spec_active` falls in the same cycle as `busy`.
- R8: A commit sweep clears the speculative flag and keeps valid and dirty set, so evicting a committed line later raises `wb_valid` with its tag and no overflow.
- R9: A rollback sweep invalidates every line whose speculative flag is set. Lines that are not speculative keep their contents and still hit.
- R10: A request presented while `busy` is high is not accepted, and `rsp_valid` stays low in the following cycle.
- R11: A commit or rollback received while speculation is inactive is ignored: `busy` stays low.
- R12: An access accepted in the same cycle as a command uses the mode in force before that command. A write together with a begin is a normal write and survives a later rollback. A write together with a rollback is speculative and is removed by that rollback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Cache access request |
| acc_write | input | 1 | Access is a write (1) or a read (0) |
| acc_index | input | INDEX_W | Line index of the access |
| acc_tag | input | TAG_W | Tag of the access |
| cmd_begin | input | 1 | Start a speculative section |
| cmd_commit | input | 1 | End speculation, keep speculative data |
| cmd_rollback | input | 1 | End speculation, discard speculative data |
| rsp_valid | output | 1 | Response for the access accepted in the previous cycle |
| rsp_hit | output | 1 | That access hit |
| evict_ovf | output | 1 | That access missed and its only victim is speculative |
| wb_valid | output | 1 | Write-back request to memory |
| wb_index | output | INDEX_W | Line index to write back |
| wb_tag | output | TAG_W | Tag of the line to write back |
| busy | output | 1 | Sweep or restore in progress; accesses are refused |
| spec_active | output | 1 | Speculative mode is on |

## Verification
The collision that matters most is an access and a speculation command arriving in the same cycle. Each of the two sides could plausibly see the old mode or the new one. The bench drives a write together with a begin, and later a write together with a rollback, onto lines not touched otherwise. It then judges the outcome after the sweep by reading both lines back: the first must still hit and the second must miss. A second overlap, a request arriving in the first sweep cycle, is judged by the absence of a response.

// File: rtl/slm_pkg.sv
package slm_pkg;

  typedef struct packed {
    logic valid;
    logic dirty;
    logic spec;
  } line_flags_t;

  typedef enum logic [1:0] {
    SW_IDLE    = 2'd0,
    SW_WALK    = 2'd1,
    SW_RESTORE = 2'd2
  } sweep_state_t;

  typedef enum logic {
    END_MERGE   = 1'b0,
    END_DISCARD = 1'b1
  } end_mode_t;

endpackage

// File: rtl/slm_line_array.sv
module slm_line_array
  import slm_pkg::*;
#(
  parameter int INDEX_W = 4,
  parameter int TAG_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [INDEX_W-1:0] waddr,
  input  line_flags_t        wflags,
  input  logic [TAG_W-1:0]   wtag,
  input  logic [INDEX_W-1:0] raddr_a,
  output line_flags_t        rflags_a,
  output logic [TAG_W-1:0]   rtag_a,
  input  logic [INDEX_W-1:0] raddr_b,
  output line_flags_t        rflags_b,
  output logic [TAG_W-1:0]   rtag_b
);
  localparam int LINES = 1 << INDEX_W;

  line_flags_t      flags_q [LINES];
  logic [TAG_W-1:0] tags_q  [LINES];

  // Flags need a reset, so they live in per-line registers.
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        flags_q[g] <= '0;
      end else if (we && waddr == INDEX_W'(g)) begin
        flags_q[g] <= wflags;
      end
    end
  end

  // Tags need no reset and can map onto a RAM.
  always_ff @(posedge clk) begin
    if (we) begin
      tags_q[waddr] <= wtag;
    end
  end

  assign rflags_a = flags_q[raddr_a];
  assign rtag_a   = tags_q[raddr_a];
  assign rflags_b = flags_q[raddr_b];
  assign rtag_b   = tags_q[raddr_b];

  // R9
  rollback_clears_all_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !wflags.valid) |-> (!wflags.dirty && !wflags.spec));

endmodule

// File: rtl/slm_access_ctrl.sv
module slm_access_ctrl
  import slm_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             fire,
  input  logic             is_write,
  input  logic [TAG_W-1:0] tag,
  input  logic             spec_on,
  input  line_flags_t      cur_flags,
  input  logic [TAG_W-1:0] cur_tag,
  output logic             hit,
  output logic             ovf,
  output logic             wb,
  output logic [TAG_W-1:0] wb_tag,
  output logic             we,
  output line_flags_t      new_flags,
  output logic [TAG_W-1:0] new_tag
);
  logic match;
  logic victim_locked;

  assign match         = cur_flags.valid && (cur_tag == tag);
  assign victim_locked = cur_flags.valid && cur_flags.spec;

  always_comb begin
    hit       = 1'b0;
    ovf       = 1'b0;
    wb        = 1'b0;
    wb_tag    = cur_tag;
    we        = 1'b0;
    new_flags = cur_flags;
    new_tag   = cur_tag;
    if (fire) begin
      if (match) begin
        hit = 1'b1;
        if (is_write) begin
          we              = 1'b1;
          new_flags.dirty = 1'b1;
          new_flags.spec  = cur_flags.spec | spec_on;
          // Save the safe copy before the first speculative write.
          wb              = spec_on && cur_flags.dirty && !cur_flags.spec;
        end
      end else if (victim_locked) begin
        ovf = 1'b1;
      end else begin
        wb              = cur_flags.valid && cur_flags.dirty;
        we              = 1'b1;
        new_flags.valid = 1'b1;
        new_flags.dirty = is_write;
        new_flags.spec  = is_write && spec_on;
        new_tag         = tag;
      end
    end
  end

endmodule

// File: rtl/slm_sweep_ctrl.sv
module slm_sweep_ctrl
  import slm_pkg::*;
#(
  parameter int INDEX_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_begin,
  input  logic               cmd_commit,
  input  logic               cmd_rollback,
  input  line_flags_t        cur_flags,
  output logic [INDEX_W-1:0] ptr,
  output logic               we,
  output line_flags_t        new_flags,
  output logic               busy,
  output logic               spec_on
);
  localparam logic [INDEX_W-1:0] LAST = '1;

  sweep_state_t state_q;
  end_mode_t    mode_q;
  logic [INDEX_W-1:0] ptr_q;
  logic         spec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SW_IDLE;
      mode_q  <= END_MERGE;
      ptr_q   <= '0;
      spec_q  <= 1'b0;
    end else begin
      unique case (state_q)
        SW_IDLE: begin
          if (spec_q && (cmd_rollback || cmd_commit)) begin
            state_q <= SW_WALK;
            ptr_q   <= '0;
            mode_q  <= cmd_rollback ? END_DISCARD : END_MERGE;
          end else if (cmd_begin && !spec_q) begin
            spec_q <= 1'b1;
          end
        end
        SW_WALK: begin
          ptr_q <= ptr_q + 1'b1;
          if (ptr_q == LAST) begin
            state_q <= SW_RESTORE;
          end
        end
        SW_RESTORE: begin
          spec_q  <= 1'b0;
          state_q <= SW_IDLE;
        end
        default: state_q <= SW_IDLE;
      endcase
    end
  end

  always_comb begin
    we        = (state_q == SW_WALK) && cur_flags.spec;
    new_flags = cur_flags;
    new_flags.spec = 1'b0;
    if (mode_q == END_DISCARD) begin
      new_flags = '0;
    end
  end

  assign ptr     = ptr_q;
  assign busy    = (state_q != SW_IDLE);
  assign spec_on = spec_q;

  // R7
  sweep_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SW_WALK && ptr_q != LAST) |=> (state_q == SW_WALK && ptr_q == $past(ptr_q) + 1'b1));

  // R7
  spec_ends_in_restore_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(spec_q) |-> ($past(state_q) == SW_RESTORE));

  // R4
  spec_held_in_sweep_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SW_WALK) |-> spec_q);

endmodule

// File: rtl/spec_line_mgr.sv
module spec_line_mgr
  import slm_pkg::*;
#(
  parameter int INDEX_W = 4,
  parameter int TAG_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_req,
  input  logic               acc_write,
  input  logic [INDEX_W-1:0] acc_index,
  input  logic [TAG_W-1:0]   acc_tag,
  input  logic               cmd_begin,
  input  logic               cmd_commit,
  input  logic               cmd_rollback,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               evict_ovf,
  output logic               wb_valid,
  output logic [INDEX_W-1:0] wb_index,
  output logic [TAG_W-1:0]   wb_tag,
  output logic               busy,
  output logic               spec_active
);
  logic [INDEX_W-1:0] sw_ptr;
  logic               sw_we;
  line_flags_t        sw_flags;
  logic               sw_busy;
  logic               sw_spec;

  line_flags_t        a_flags;
  logic [TAG_W-1:0]   a_tag;
  line_flags_t        b_flags;
  logic [TAG_W-1:0]   b_tag;

  logic               fire;
  logic               ac_hit;
  logic               ac_ovf;
  logic               ac_wb;
  logic [TAG_W-1:0]   ac_wb_tag;
  logic               ac_we;
  line_flags_t        ac_flags;
  logic [TAG_W-1:0]   ac_tag_new;

  logic               arr_we;
  logic [INDEX_W-1:0] arr_waddr;
  line_flags_t        arr_wflags;
  logic [TAG_W-1:0]   arr_wtag;

  assign fire = acc_req && !sw_busy;

  slm_sweep_ctrl #(.INDEX_W(INDEX_W)) sweep_i (
    .clk          (clk),
    .rst          (rst),
    .cmd_begin    (cmd_begin),
    .cmd_commit   (cmd_commit),
    .cmd_rollback (cmd_rollback),
    .cur_flags    (b_flags),
    .ptr          (sw_ptr),
    .we           (sw_we),
    .new_flags    (sw_flags),
    .busy         (sw_busy),
    .spec_on      (sw_spec)
  );

  slm_access_ctrl #(.TAG_W(TAG_W)) access_i (
    .fire      (fire),
    .is_write  (acc_write),
    .tag       (acc_tag),
    .spec_on   (sw_spec),
    .cur_flags (a_flags),
    .cur_tag   (a_tag),
    .hit       (ac_hit),
    .ovf       (ac_ovf),
    .wb        (ac_wb),
    .wb_tag    (ac_wb_tag),
    .we        (ac_we),
    .new_flags (ac_flags),
    .new_tag   (ac_tag_new)
  );

  // One write port: the sweep and the access path never write together.
  always_comb begin
    arr_we     = sw_we | ac_we;
    arr_waddr  = sw_we ? sw_ptr   : acc_index;
    arr_wflags = sw_we ? sw_flags : ac_flags;
    arr_wtag   = sw_we ? b_tag    : ac_tag_new;
  end

  slm_line_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) lines_i (
    .clk      (clk),
    .rst      (rst),
    .we       (arr_we),
    .waddr    (arr_waddr),
    .wflags   (arr_wflags),
    .wtag     (arr_wtag),
    .raddr_a  (acc_index),
    .rflags_a (a_flags),
    .rtag_a   (a_tag),
    .raddr_b  (sw_ptr),
    .rflags_b (b_flags),
    .rtag_b   (b_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      evict_ovf <= 1'b0;
      wb_valid  <= 1'b0;
      wb_index  <= '0;
      wb_tag    <= '0;
    end else begin
      rsp_valid <= fire;
      rsp_hit   <= ac_hit;
      evict_ovf <= ac_ovf;
      wb_valid  <= ac_wb;
      wb_index  <= acc_index;
      wb_tag    <= ac_wb_tag;
    end
  end

  assign busy        = sw_busy;
  assign spec_active = sw_spec;

  // R6
  spec_victim_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && a_flags.valid && a_flags.spec && a_tag != acc_tag) |=> (evict_ovf && !wb_valid && !rsp_hit));

  // R10
  no_rsp_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !rsp_valid);

  // R2
  ovf_not_hit_chk: assert property (@(posedge clk) disable iff (rst)
    evict_ovf |-> (rsp_valid && !rsp_hit && !wb_valid));

  // R7
  single_writer_chk: assert property (@(posedge clk) disable iff (rst)
    !(sw_we && ac_we));

endmodule

// File: tb/spec_line_mgr_tb_top.sv
`timescale 1ns/1ps
module spec_line_mgr_tb_top;
  localparam int INDEX_W = 4;
  localparam int TAG_W   = 8;
  localparam int LINES   = 1 << INDEX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_req = 1'b0, acc_write = 1'b0;
  logic [INDEX_W-1:0] acc_index = '0;
  logic [TAG_W-1:0]   acc_tag = '0;
  logic cmd_begin = 1'b0, cmd_commit = 1'b0, cmd_rollback = 1'b0;
  logic rsp_valid, rsp_hit, evict_ovf, wb_valid, busy, spec_active;
  logic [INDEX_W-1:0] wb_index;
  logic [TAG_W-1:0]   wb_tag;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  spec_line_mgr #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst(rst), .acc_req(acc_req), .acc_write(acc_write),
    .acc_index(acc_index), .acc_tag(acc_tag), .cmd_begin(cmd_begin),
    .cmd_commit(cmd_commit), .cmd_rollback(cmd_rollback),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .evict_ovf(evict_ovf),
    .wb_valid(wb_valid), .wb_index(wb_index), .wb_tag(wb_tag),
    .busy(busy), .spec_active(spec_active)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One access, outputs observed at the following falling edge.
  task automatic acc(input logic wr, input int idx, input int tag);
    @(negedge clk);
    acc_req = 1'b1; acc_write = wr;
    acc_index = INDEX_W'(idx); acc_tag = TAG_W'(tag);
    @(negedge clk);
    acc_req = 1'b0; acc_write = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input int hit, input int wb, input int ovf);
    chk(req, "rsp_valid", int'(rsp_valid), 1);
    chk(req, "rsp_hit", int'(rsp_hit), hit);
    chk(req, "wb_valid", int'(wb_valid), wb);
    chk(req, "evict_ovf", int'(evict_ovf), ovf);
  endtask

  task automatic pulse_cmd(input int which);
    @(negedge clk);
    cmd_begin = (which == 0); cmd_commit = (which == 1); cmd_rollback = (which == 2);
    @(negedge clk);
    cmd_begin = 1'b0; cmd_commit = 1'b0; cmd_rollback = 1'b0;
  endtask

  // Counts busy cycles starting at the current falling edge.
  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 4 * LINES) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "spec_active", int'(spec_active), 0);
    chk("R1", "rsp_valid", int'(rsp_valid), 0);
    chk("R1", "wb_valid", int'(wb_valid), 0);
    acc(1'b0, 0, 0);
    expect_rsp("R1", 0, 0, 0);
  endtask

  task automatic t_normal();
    acc(1'b0, 3, 5);  expect_rsp("R2", 0, 0, 0);
    acc(1'b0, 3, 5);  expect_rsp("R2", 1, 0, 0);
    acc(1'b1, 3, 5);  expect_rsp("R3", 1, 0, 0);
    acc(1'b0, 3, 6);  expect_rsp("R3", 0, 1, 0);
    chk("R3", "wb_index", int'(wb_index), 3);
    chk("R3", "wb_tag", int'(wb_tag), 5);
    acc(1'b0, 3, 5);  expect_rsp("R2", 0, 0, 0);  // clean victim tag 6 -> no wb
    acc(1'b0, 3, 6);  expect_rsp("R2", 0, 0, 0);
    acc(1'b1, 3, 6);  expect_rsp("R3", 1, 0, 0);
    acc(1'b0, 5, 1);  expect_rsp("R2", 0, 0, 0);
  endtask

  task automatic t_spec_write();
    pulse_cmd(0);
    chk("R4", "spec_active", int'(spec_active), 1);
    pulse_cmd(0);
    chk("R4", "busy after repeat begin", int'(busy), 0);
    chk("R4", "spec_active after repeat begin", int'(spec_active), 1);
    acc(1'b1, 3, 6);  expect_rsp("R5", 1, 1, 0);
    chk("R5", "wb_index", int'(wb_index), 3);
    chk("R5", "wb_tag", int'(wb_tag), 6);
    acc(1'b1, 3, 6);  expect_rsp("R5", 1, 0, 0);
    acc(1'b1, 4, 2);  expect_rsp("R5", 0, 0, 0);
  endtask

  task automatic t_overflow();
    acc(1'b0, 3, 9);  expect_rsp("R6", 0, 0, 1);
    acc(1'b1, 4, 7);  expect_rsp("R6", 0, 0, 1);
    acc(1'b0, 3, 6);  expect_rsp("R6", 1, 0, 0);
  endtask

  task automatic t_rollback_stall();
    int n;
    pulse_cmd(2);
    chk("R7", "busy start", int'(busy), 1);
    acc_req = 1'b1; acc_index = 4'd5; acc_tag = 8'd1;
    @(negedge clk);
    acc_req = 1'b0;
    chk("R10", "rsp_valid during sweep", int'(rsp_valid), 0);
    count_busy(n);
    chk("R7", "busy cycles", n + 1, LINES + 1);
    chk("R7", "spec_active after sweep", int'(spec_active), 0);
    acc(1'b0, 3, 6);  expect_rsp("R9", 0, 0, 0);
    acc(1'b0, 4, 2);  expect_rsp("R9", 0, 0, 0);
    acc(1'b0, 5, 1);  expect_rsp("R9", 1, 0, 0);
  endtask

  task automatic t_commit();
    int n;
    pulse_cmd(0);
    acc(1'b1, 7, 9);  expect_rsp("R8", 0, 0, 0);
    pulse_cmd(1);
    count_busy(n);
    chk("R7", "commit busy cycles", n, LINES + 1);
    chk("R7", "spec_active after commit", int'(spec_active), 0);
    acc(1'b0, 7, 9);  expect_rsp("R8", 1, 0, 0);
    acc(1'b0, 7, 1);  expect_rsp("R8", 0, 1, 0);
    chk("R8", "wb_tag", int'(wb_tag), 9);
    chk("R8", "wb_index", int'(wb_index), 7);
  endtask

  task automatic t_ignored();
    pulse_cmd(1);
    chk("R11", "busy after idle commit", int'(busy), 0);
    pulse_cmd(2);
    chk("R11", "busy after idle rollback", int'(busy), 0);
    chk("R11", "spec_active", int'(spec_active), 0);
    acc(1'b0, 5, 1);  expect_rsp("R11", 1, 0, 0);
  endtask

  task automatic t_same_cycle();
    int n;
    @(negedge clk);
    cmd_begin = 1'b1; acc_req = 1'b1; acc_write = 1'b1; acc_index = 4'd8; acc_tag = 8'd3;
    @(negedge clk);
    cmd_begin = 1'b0; acc_req = 1'b0; acc_write = 1'b0;
    expect_rsp("R12", 0, 0, 0);
    chk("R12", "spec_active", int'(spec_active), 1);
    @(negedge clk);
    cmd_rollback = 1'b1; acc_req = 1'b1; acc_write = 1'b1; acc_index = 4'd9; acc_tag = 8'd4;
    @(negedge clk);
    cmd_rollback = 1'b0; acc_req = 1'b0; acc_write = 1'b0;
    expect_rsp("R12", 0, 0, 0);
    count_busy(n);
    chk("R12", "sweep length", n, LINES + 1);
    acc(1'b0, 9, 4);  expect_rsp("R12", 0, 0, 0);
    acc(1'b0, 8, 3);  expect_rsp("R12", 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_spec_write();
    t_overflow();
    t_rollback_stall();
    t_commit();
    t_ignored();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule